// File: doc/BRIEF.md
# Static LCD Backplane Segment Driver

This block drives a directly connected (static, non-multiplexed) liquid-crystal display for a three-and-a-half digit reading. It accepts a held result made of three BCD digits, a leading "1" bit for the half digit, a sign bit and an overrange flag. From these it drives one backplane line and one line per segment: three full seven-segment digits, the two segments of the half digit and a minus sign.

The backplane is a 50% duty square wave, generated by dividing the input clock first by a small prescale count and then by a larger count, 800 clocks per period by default. A segment that should be dark is driven in phase with the backplane. A lit segment is driven in antiphase. Because of this, no segment ever sees a net DC voltage in normal operation.

A lamp-test input lights every segment as a steady level, which reads as "-1888". An overrange blanks the three low digits. A helper output drives a fixed decimal point as the XOR of its select input and the backplane.

Top module: `lcd_static_driver`

## Requirements
- R1: `bp_out` is a 50% square wave that toggles every PRE_DIV*MAIN_DIV/2 clocks (400 by default). The first toggle falls on the 400th rising edge after reset is released.
- R2: While `rst` is high, `bp_out` is 0 and every segment output is 0, and `dp_out` equals `dp_sel`.
- R3: Segment vectors use bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f, bit 6 = g. BCD codes 0 to 9 light the usual patterns (0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F). A lit segment is driven as the inverse of `bp_out`, and a dark segment is driven equal to `bp_out`.
- R4: BCD codes 10 to 15 light no segment of that digit.
- R5: When lamp test is off, `seg_minus` is lit exactly when `neg` was 1 at the last backplane toggle.
- R6: `seg_half[0]` (segment b) and `seg_half[1]` (segment c) are both lit when `half_one` is 1, and both are dark otherwise.
- R7: When `ovr` is 1, all three low digits are dark. The half digit and the minus sign still follow their inputs.
- R8: When `lamp` is 1, every segment output is held at a constant 1 and `bp_out` keeps toggling. Lamp test takes priority over `ovr`.
- R9: Inputs are sampled only on the clock edge where `bp_out` toggles, and segment outputs change only on that edge. An input value that is replaced before the next toggle has no effect.
- R10: `dp_out` equals `dp_sel XOR bp_out` at all times, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bcd_ones | input | 4 | Units digit, BCD |
| bcd_tens | input | 4 | Tens digit, BCD |
| bcd_hund | input | 4 | Hundreds digit, BCD |
| half_one | input | 1 | Leading half digit shows "1" |
| neg | input | 1 | Result is negative |
| ovr | input | 1 | Overrange flag |
| lamp | input | 1 | Lamp test |
| dp_sel | input | 1 | Decimal-point select |
| bp_out | output | 1 | Backplane square wave |
| seg_ones | output | 7 | Units digit segments a..g |
| seg_tens | output | 7 | Tens digit segments a..g |
| seg_hund | output | 7 | Hundreds digit segments a..g |
| seg_half | output | 2 | Half digit segments b (bit 0) and c (bit 1) |
| seg_minus | output | 1 | Minus sign segment |
| dp_out | output | 1 | Decimal-point drive |

## Verification
Every segment result is due on the first rising edge where the backplane toggles after the stimulus is applied. That edge is up to 400 clocks later, and the result is then held for a full half period. The only immediate result is `dp_out`, which must follow `dp_sel` and the backplane in the same cycle.

The bench queues one expectation for each backplane toggle. The monitor compares it only when it sees `bp_out` change, and at the same point it checks the toggle spacing. In every cycle between toggles the monitor also confirms that no segment line moved, which covers input values that are replaced mid-phase.

// File: rtl/lcd_static_pkg.sv
package lcd_static_pkg;

    // Seven-segment pattern, bit 0 = a ... bit 6 = g
    typedef logic [6:0] seg7_t;

    // Full set of segment lines, most significant field first
    typedef struct packed {
        seg7_t      hund;
        seg7_t      tens;
        seg7_t      ones;
        logic [1:0] half;   // [0] = b, [1] = c
        logic       minus;
    } seg_frame_t;

    localparam int FRAME_W = $bits(seg_frame_t);

    // Raw reading handed to the decoder
    typedef struct packed {
        logic [3:0] hund;
        logic [3:0] tens;
        logic [3:0] ones;
        logic       half_one;
        logic       neg;
        logic       ovr;
    } reading_t;

    function automatic seg7_t bcd_to_seg7(input logic [3:0] code);
        seg7_t p;
        case (code)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
    parameter int PRE_DIV  = 4,
    parameter int MAIN_DIV = 200
) (
    input  logic clk,
    input  logic rst,
    output logic phase_flip
);
    localparam int HALF   = MAIN_DIV / 2;
    localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic              tick;
    logic [HALF_W-1:0] ph_q;

    generate
        if (PRE_DIV > 1) begin : g_pre
            localparam int PW = $clog2(PRE_DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst)
                    pre_q <= '0;
                else if (pre_q == PW'(PRE_DIV - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PW'(PRE_DIV - 1));
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (tick) begin
            if (ph_q == HALF_W'(HALF - 1))
                ph_q <= '0;
            else
                ph_q <= ph_q + 1'b1;
        end
    end

    assign phase_flip = tick && (ph_q == HALF_W'(HALF - 1));

    assert_half_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ph_q} < (HALF_W + 1)'(HALF)));

endmodule

// File: rtl/lcd_seg_decode.sv
module lcd_seg_decode
    import lcd_static_pkg::*;
(
    input  reading_t   rd,
    output seg_frame_t lit
);
    always_comb begin
        lit.minus = rd.neg;
        lit.half  = {2{rd.half_one}};
        if (rd.ovr) begin
            lit.ones = '0;
            lit.tens = '0;
            lit.hund = '0;
        end else begin
            lit.ones = bcd_to_seg7(rd.ones);
            lit.tens = bcd_to_seg7(rd.tens);
            lit.hund = bcd_to_seg7(rd.hund);
        end
    end
endmodule

// File: rtl/lcd_phase_drive.sv
module lcd_phase_drive
    import lcd_static_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flip,
    input  logic       lamp,
    input  seg_frame_t lit,
    output logic       bp,
    output seg_frame_t drive
);
    logic       bp_q;
    seg_frame_t drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q    <= 1'b0;
            drive_q <= '0;
        end else if (flip) begin
            bp_q <= ~bp_q;
            if (lamp)
                drive_q <= '1;
            else
                drive_q <= lit ^ {FRAME_W{~bp_q}};
        end
    end

    assign bp    = bp_q;
    assign drive = drive_q;

    assert_bp_moves_on_flip_R1: assert property (@(posedge clk) disable iff (rst)
        $changed(bp_q) |-> $past(flip));

    assert_segs_still_mid_phase_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(bp_q) |-> $stable(drive_q));

    assert_lamp_all_high_R8: assert property (@(posedge clk) disable iff (rst)
        (flip && lamp) |=> (drive_q == '1));

endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
    import lcd_static_pkg::*;
#(
    parameter int PRE_DIV  = 4,
    parameter int MAIN_DIV = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bcd_ones,
    input  logic [3:0] bcd_tens,
    input  logic [3:0] bcd_hund,
    input  logic       half_one,
    input  logic       neg,
    input  logic       ovr,
    input  logic       lamp,
    input  logic       dp_sel,
    output logic       bp_out,
    output logic [6:0] seg_ones,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hund,
    output logic [1:0] seg_half,
    output logic       seg_minus,
    output logic       dp_out
);
    logic       flip;
    reading_t   rd;
    seg_frame_t lit;
    seg_frame_t drive;

    assign rd = '{hund: bcd_hund, tens: bcd_tens, ones: bcd_ones,
                  half_one: half_one, neg: neg, ovr: ovr};

    lcd_bp_divider #(.PRE_DIV(PRE_DIV), .MAIN_DIV(MAIN_DIV)) u_div (
        .clk        (clk),
        .rst        (rst),
        .phase_flip (flip)
    );

    lcd_seg_decode u_dec (
        .rd  (rd),
        .lit (lit)
    );

    lcd_phase_drive u_drv (
        .clk   (clk),
        .rst   (rst),
        .flip  (flip),
        .lamp  (lamp),
        .lit   (lit),
        .bp    (bp_out),
        .drive (drive)
    );

    assign seg_hund  = drive.hund;
    assign seg_tens  = drive.tens;
    assign seg_ones  = drive.ones;
    assign seg_half  = drive.half;
    assign seg_minus = drive.minus;
    assign dp_out    = dp_sel ^ bp_out;

    assert_ovr_blanks_low_R7: assert property (@(posedge clk) disable iff (rst)
        (flip && !lamp && ovr) |=> ({seg_hund, seg_tens, seg_ones} == {21{bp_out}}));

    assert_minus_follows_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (flip && !lamp) |=> (seg_minus == (bp_out ^ $past(neg))));

    assert_half_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (flip && !lamp) |=> (seg_half == {2{bp_out ^ $past(half_one)}}));

endmodule

// File: tb/test_lcd_static_driver.sv
module test_lcd_static_driver;

    localparam int HALF_PERIOD = 400;

    typedef struct {
        logic [3:0] h, t, o;
        logic       half, neg, ovr, lamp;
    } stim_t;

    typedef struct {
        logic [23:0] lit;
        logic        lamp;
        string       tag;
    } exp_t;

    logic       clk = 0, rst = 1;
    logic [3:0] bcd_ones = 0, bcd_tens = 0, bcd_hund = 0;
    logic       half_one = 0, neg = 0, ovr = 0, lamp = 0, dp_sel = 0;
    logic       bp_out, seg_minus, dp_out;
    logic [6:0] seg_ones, seg_tens, seg_hund;
    logic [1:0] seg_half;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    lcd_static_driver i_lcd_static_driver (
        .clk(clk), .rst(rst), .bcd_ones(bcd_ones), .bcd_tens(bcd_tens),
        .bcd_hund(bcd_hund), .half_one(half_one), .neg(neg), .ovr(ovr),
        .lamp(lamp), .dp_sel(dp_sel), .bp_out(bp_out), .seg_ones(seg_ones),
        .seg_tens(seg_tens), .seg_hund(seg_hund), .seg_half(seg_half),
        .seg_minus(seg_minus), .dp_out(dp_out)
    );

    wire [23:0] frame_out = {seg_hund, seg_tens, seg_ones, seg_half, seg_minus};

    function automatic logic [6:0] ref_digit(input logic [3:0] c);
        logic [6:0] tbl [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return (c < 10) ? tbl[c] : 7'h00;
    endfunction

    function automatic logic [23:0] ref_lit(input stim_t s);
        logic [20:0] low;
        low = s.ovr ? 21'h0 : {ref_digit(s.h), ref_digit(s.t), ref_digit(s.o)};
        return {low, {2{s.half}}, s.neg};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [23:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input stim_t s);
        bcd_hund <= s.h; bcd_tens <= s.t; bcd_ones <= s.o;
        half_one <= s.half; neg <= s.neg; ovr <= s.ovr; lamp <= s.lamp;
    endtask

    // driver: drive a reading and queue what the next toggle must show
    task automatic send(input stim_t s, input string tag);
        exp_t e;
        apply(s);
        e.lit = ref_lit(s); e.lamp = s.lamp; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    // monitor
    int   cyc = 0;
    bit   moved = 0;
    logic last_bp;
    logic [23:0] last_frame;
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; moved = 0; last_bp = bp_out; last_frame = frame_out;
        end else begin
            cyc++;
            if (bp_out != last_bp) begin
                check(cyc == HALF_PERIOD, "R1 toggle spacing", 24'(cyc), 24'(HALF_PERIOD));
                check(!moved, "R9 segments still mid-phase", 24'(moved), 24'd0);
                if (q.size() > 0) begin
                    exp_t e;
                    logic [23:0] want;
                    e = q.pop_front();
                    want = e.lamp ? 24'hFFFFFF : (e.lit ^ {24{bp_out}});
                    check(frame_out == want, e.tag, frame_out, want);
                end
                cyc = 0; moved = 0;
            end else if (frame_out != last_frame) begin
                moved = 1;
            end
            last_bp = bp_out; last_frame = frame_out;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        stim_t s;
        dp_sel = 1;
        repeat (4) @(negedge clk);
        check(bp_out == 0 && frame_out == 0, "R2 reset outputs", frame_out, 24'h0);
        check(dp_out == 1, "R2 dp during reset", 24'(dp_out), 24'd1);
        @(negedge clk); rst <= 0;

        // R3: every digit value, each held for both backplane polarities
        for (int i = 0; i < 10; i++) begin
            s = '{h: 4'((i + 3) % 10), t: 4'(9 - i), o: 4'(i),
                  half: 0, neg: 0, ovr: 0, lamp: 0};
            send(s, $sformatf("R3 digits %0d", i));
            send(s, $sformatf("R3 digits %0d other phase", i));
        end
        // R4: non-decimal codes blank
        for (int c = 10; c < 16; c++) begin
            s = '{h: 4'(c), t: 4'(c), o: 4'(c), half: 0, neg: 0, ovr: 0, lamp: 0};
            send(s, $sformatf("R4 code %0d blank", c));
        end
        s = '{h: 4'd5, t: 4'd12, o: 4'd7, half: 0, neg: 0, ovr: 0, lamp: 0};
        send(s, "R4 mixed blank digit");
        // R5 and R6
        s = '{h: 4'd2, t: 4'd4, o: 4'd6, half: 0, neg: 1, ovr: 0, lamp: 0};
        send(s, "R5 minus lit");
        send(s, "R5 minus lit other phase");
        s = '{h: 4'd0, t: 4'd0, o: 4'd1, half: 1, neg: 0, ovr: 0, lamp: 0};
        send(s, "R6 half digit lit");
        send(s, "R6 half digit lit other phase");
        // R7: overrange keeps half and sign
        s = '{h: 4'd8, t: 4'd8, o: 4'd8, half: 1, neg: 1, ovr: 1, lamp: 0};
        send(s, "R7 overrange blanks low digits");
        send(s, "R7 overrange other phase");
        // R8: lamp test wins over overrange, held steady
        s = '{h: 4'd3, t: 4'd0, o: 4'd9, half: 0, neg: 0, ovr: 1, lamp: 1};
        send(s, "R8 lamp test all on");
        send(s, "R8 lamp test steady");
        // R9: a value replaced mid-phase never shows; R10 checked in that window
        begin
            stim_t x, y;
            exp_t e;
            x = '{h: 4'd1, t: 4'd1, o: 4'd1, half: 1, neg: 1, ovr: 0, lamp: 0};
            y = '{h: 4'd7, t: 4'd3, o: 4'd5, half: 0, neg: 0, ovr: 0, lamp: 0};
            apply(x);
            repeat (100) @(negedge clk);
            dp_sel <= 1;
            @(negedge clk);
            check(dp_out == (1'b1 ^ bp_out), "R10 dp select high", 24'(dp_out), 24'(~bp_out));
            dp_sel <= 0;
            @(negedge clk);
            check(dp_out == bp_out, "R10 dp select low", 24'(dp_out), 24'(bp_out));
            repeat (50) @(negedge clk);
            apply(y);
            e.lit = ref_lit(y); e.lamp = 0; e.tag = "R9 replaced value ignored";
            q.push_back(e);
            wait (q.size() == 0);
        end
        s = '{h: 4'd4, t: 4'd2, o: 4'd0, half: 1, neg: 0, ovr: 0, lamp: 0};
        send(s, "R8 return from lamp test");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule